// File: doc/BRIEF.md
# SD Card SPI-Mode Start-Up Sequencer

This block brings a memory card from power-up to a ready state over SPI, with no software involved. A single `start` pulse runs the whole flow. The block sends a burst of idle clocks with chip-select released. It then sends the reset command and the interface-check command. The interface-check answer decides whether the card is a standard-capacity part or a newer high-capacity part. The block then repeats the application-specific initialization pair until the card reports ready, and finally fixes the block length at 512 bytes.

Underneath the sequencer is a mode-0 byte engine: the clock idles low, MSB goes first, MISO is sampled on the rising SCK edge and MOSI changes on the falling edge. Every command is a six-byte frame. After each frame the sequencer polls with 0xFF bytes for a one-byte R1 answer, releases chip-select and sends one trailing 0xFF byte. When the run ends, `ready` or `error` is held together with the last answer byte and the card-type flag, until the next `start`.

Top module: `sdspi_boot`

## Requirements
- R1: The SPI link is mode 0. SCK is low whenever the block is idle, MOSI never changes while SCK is high, and every byte goes out MSB first.
- R2: After `start`, at least 74 SCK rising edges occur with `cs_n` high and MOSI high before `cs_n` first goes low. With the default of 80 cycles, this burst is ten 0xFF bytes.
- R3: A command frame is sent with `cs_n` low, in this order: index OR 0x40, the 32-bit argument MSB byte first, then the CRC byte. The frames are: reset 40 00 00 00 00 95; interface check 48 00 00 01 AA 87; app prefix 77 00 00 00 00 00; init 69 40 00 00 00 00 after a 0x01 interface answer, or 69 00 00 00 00 00 after a 0x05 answer; block length 50 00 00 02 00 00.
- R4: After each frame the block keeps `cs_n` low and clocks 0xFF bytes until it reads a byte with bit 7 clear, for at most 8 bytes. If no such byte arrives, the run ends with `error` and `last_r1` = 0xFF.
- R5: The reset command must be answered with 0x01. Any other answer ends the run with `error`.
- R6: On the interface check, an answer of 0x01 sets `card_new`. The block then reads four more bytes, and the last of them must be 0xAA, otherwise `error`. An answer of 0x05 leaves `card_new` = 0 and skips those bytes. Any other answer gives `error`.
- R7: Initialization sends the app prefix (which accepts answer 0x00 or 0x01) and then the init command. An init answer of 0x01 repeats the pair and an answer of 0x00 moves on. If the init command has answered 0x01 RETRY_LIMIT times, the run ends with `error`.
- R8: After the init command answers 0x00, the block-length command is sent. An answer of 0x00 ends with `ready`, and anything else ends with `error`.
- R9: After every command's last polled byte (including a failing one), `cs_n` goes high and exactly one 0xFF byte is clocked before the next frame or the end of the run.
- R10: `last_r1` is set to 0xFF on `start` and then holds the most recent answer byte with bit 7 clear. It does not hold the four trailing interface-check bytes.
- R11: `busy` is high from the cycle after `start` until the final trailing byte has finished. `ready` and `error` are low while busy, never high together, and held afterwards. A `start` pulse while busy is ignored.
- R12: Out of reset: `cs_n`=1, `sck`=0, `mosi`=1, `busy`=0, `ready`=0, `error`=0, `card_new`=0, `last_r1`=0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | One-cycle request to run the start-up flow |
| miso | input | 1 | Serial data from the card |
| cs_n | output | 1 | Card select, active low |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to the card |
| busy | output | 1 | Flow in progress |
| ready | output | 1 | Flow finished with the card ready |
| error | output | 1 | Flow finished with a failure |
| card_new | output | 1 | 1 = high-capacity (interface check answered 0x01), 0 = standard capacity |
| last_r1 | output | 8 | Most recent answer byte |

## Verification
A behavioural card model answers each frame after a chosen number of 0xFF busy bytes. It is run through eight personalities, and each one separates a different branch:
- a high-capacity card that needs two init retries;
- a standard card that is ready on the first try;
- a wrong reset answer;
- a silent card, which can only end in a timeout;
- a card that never leaves idle, which can only hit the retry limit;
- a bad interface-check echo;
- an unknown interface-check answer;
- a rejected block length.

The full bus stream, including the chip-select level of every byte, is compared with a queue built from the requirements. This means a missing trailing byte, a wrong poll count or a wrong init argument shows up at the exact byte where it happens. A stray `start` in the middle of a run is included to show that it cannot restart the flow.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_FRAME, ST_POLL, ST_EXTRA, ST_TAIL
  } st_t;

  typedef enum logic [2:0] {
    C_RESET, C_IFCHK, C_APP, C_INIT, C_BLKLEN
  } cmd_t;

  typedef enum logic [1:0] {
    NX_MORE, NX_OK, NX_FAIL
  } nx_t;

  function automatic logic [5:0] cmd_index(cmd_t c);
    case (c)
      C_RESET:  return 6'd0;
      C_IFCHK:  return 6'd8;
      C_APP:    return 6'd55;
      C_INIT:   return 6'd41;
      default:  return 6'd16;
    endcase
  endfunction

  function automatic logic [31:0] cmd_arg(cmd_t c, logic high_cap);
    case (c)
      C_IFCHK:  return 32'h0000_01AA;
      C_INIT:   return high_cap ? 32'h4000_0000 : 32'h0000_0000;
      C_BLKLEN: return 32'h0000_0200;
      default:  return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [7:0] cmd_crc(cmd_t c);
    case (c)
      C_RESET: return 8'h95;
      C_IFCHK: return 8'h87;
      default: return 8'h00;
    endcase
  endfunction

  // Byte number pos (0..5) of a command frame.
  function automatic logic [7:0] frame_byte(cmd_t c, logic high_cap, logic [2:0] pos);
    logic [31:0] a;
    a = cmd_arg(c, high_cap);
    case (pos)
      3'd0:    return {2'b01, cmd_index(c)};
      3'd1:    return a[31:24];
      3'd2:    return a[23:16];
      3'd3:    return a[15:8];
      3'd4:    return a[7:0];
      3'd5:    return cmd_crc(c);
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_answer(logic [7:0] b);
    return !b[7];
  endfunction

endpackage

// File: rtl/sdspi_tick.sv
module sdspi_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!en)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + W'(1);
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sdspi_shift.sv
module sdspi_shift #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi
);
  logic       active, sck_q, done_q, tick;
  logic [7:0] txs, rxs;
  logic [2:0] bitn;

  sdspi_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      txs    <= 8'hFF;
      rxs    <= 8'hFF;
      bitn   <= 3'd0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          txs    <= tx;
          bitn   <= 3'd0;
        end
      end else if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;                       // rising edge: sample
          rxs   <= {rxs[6:0], miso};
        end else begin
          sck_q <= 1'b0;                       // falling edge: next bit
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
            txs    <= 8'hFF;
          end else begin
            bitn <= bitn + 3'd1;
            txs  <= {txs[6:0], 1'b1};
          end
        end
      end
    end
  end

  assign mosi = txs[7];
  assign sck  = sck_q;
  assign done = done_q;
  assign rx   = rxs;
endmodule

// File: rtl/sdspi_seq.sv
module sdspi_seq
  import sdspi_pkg::*;
#(
  parameter int WAKE_BYTES  = 10,
  parameter int POLL_LIMIT  = 8,
  parameter int RETRY_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       done,
  input  logic [7:0] rx,
  output logic       go,
  output logic [7:0] tx,
  output logic       cs_n,
  output logic       busy,
  output logic       ready,
  output logic       error,
  output logic       card_new,
  output logic [7:0] last_r1,
  output logic       ev_timeout,
  output logic       ev_retry_over
);
  localparam int CMAX0 = (WAKE_BYTES > POLL_LIMIT) ? WAKE_BYTES : POLL_LIMIT;
  localparam int CMAX  = (CMAX0 > 6) ? CMAX0 : 6;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int TW    = $clog2(RETRY_LIMIT + 1);

  st_t          st, st_d;
  cmd_t         cmd, cmd_d;
  nx_t          nx, nx_d;
  logic [CW-1:0] cnt, cnt_d;
  logic [TW-1:0] tries, tries_d;
  logic          inflight, inflight_d;
  logic          hc, hc_d, rdy, rdy_d, err, err_d, cs_q, cs_d;
  logic [7:0]    r1, r1_d;

  assign go = (st != ST_IDLE) && !inflight;

  always_comb begin
    case (st)
      ST_FRAME: tx = frame_byte(cmd, hc, cnt[2:0]);
      default:  tx = 8'hFF;
    endcase
  end

  always_comb begin
    st_d = st; cmd_d = cmd; nx_d = nx; cnt_d = cnt; tries_d = tries;
    hc_d = hc; rdy_d = rdy; err_d = err; r1_d = r1;
    inflight_d = inflight;
    if (go)   inflight_d = 1'b1;
    if (done) inflight_d = 1'b0;
    ev_timeout    = 1'b0;
    ev_retry_over = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        st_d = ST_WAKE; cmd_d = C_RESET; nx_d = NX_MORE;
        cnt_d = '0; tries_d = '0;
        hc_d = 1'b0; rdy_d = 1'b0; err_d = 1'b0; r1_d = 8'hFF;
      end
      ST_WAKE: if (done) begin
        if (cnt == CW'(WAKE_BYTES - 1)) begin st_d = ST_FRAME; cnt_d = '0; end
        else cnt_d = cnt + CW'(1);
      end
      ST_FRAME: if (done) begin
        if (cnt == CW'(5)) begin st_d = ST_POLL; cnt_d = '0; end
        else cnt_d = cnt + CW'(1);
      end
      ST_POLL: if (done) begin
        if (is_answer(rx)) begin
          r1_d = rx; cnt_d = '0; st_d = ST_TAIL;
          case (cmd)
            C_RESET: if (rx == 8'h01) cmd_d = C_IFCHK; else nx_d = NX_FAIL;
            C_IFCHK: begin
              if (rx == 8'h01)      begin hc_d = 1'b1; st_d = ST_EXTRA; end
              else if (rx == 8'h05) cmd_d = C_APP;
              else                  nx_d = NX_FAIL;
            end
            C_APP: if (rx[7:1] == 7'd0) cmd_d = C_INIT; else nx_d = NX_FAIL;
            C_INIT: begin
              if (rx == 8'h00) cmd_d = C_BLKLEN;
              else if (rx == 8'h01) begin
                if (tries == TW'(RETRY_LIMIT - 1)) begin
                  nx_d = NX_FAIL; ev_retry_over = 1'b1;
                end else begin
                  tries_d = tries + TW'(1); cmd_d = C_APP;
                end
              end else nx_d = NX_FAIL;
            end
            default: if (rx == 8'h00) nx_d = NX_OK; else nx_d = NX_FAIL;
          endcase
        end else if (cnt == CW'(POLL_LIMIT - 1)) begin
          r1_d = 8'hFF; ev_timeout = 1'b1; nx_d = NX_FAIL;
          st_d = ST_TAIL; cnt_d = '0;
        end else cnt_d = cnt + CW'(1);
      end
      ST_EXTRA: if (done) begin
        if (cnt == CW'(3)) begin
          st_d = ST_TAIL; cnt_d = '0;
          if (rx == 8'hAA) cmd_d = C_APP; else nx_d = NX_FAIL;
        end else cnt_d = cnt + CW'(1);
      end
      default: if (done) begin        // ST_TAIL
        if (nx == NX_MORE) st_d = ST_FRAME;
        else begin
          st_d  = ST_IDLE;
          rdy_d = (nx == NX_OK);
          err_d = (nx == NX_FAIL);
        end
      end
    endcase
    cs_d = !(st_d == ST_FRAME || st_d == ST_POLL || st_d == ST_EXTRA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cmd <= C_RESET; nx <= NX_MORE;
      cnt <= '0; tries <= '0; inflight <= 1'b0;
      hc <= 1'b0; rdy <= 1'b0; err <= 1'b0; r1 <= 8'hFF; cs_q <= 1'b1;
    end else begin
      st <= st_d; cmd <= cmd_d; nx <= nx_d;
      cnt <= cnt_d; tries <= tries_d; inflight <= inflight_d;
      hc <= hc_d; rdy <= rdy_d; err <= err_d; r1 <= r1_d; cs_q <= cs_d;
    end
  end

  assign cs_n     = cs_q;
  assign busy     = (st != ST_IDLE);
  assign ready    = rdy;
  assign error    = err;
  assign card_new = hc;
  assign last_r1  = r1;
endmodule

// File: rtl/sdspi_boot.sv
module sdspi_boot #(
  parameter int CLK_DIV     = 125,
  parameter int WAKE_CYCLES = 80,
  parameter int POLL_LIMIT  = 8,
  parameter int RETRY_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       miso,
  output logic       cs_n,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       ready,
  output logic       error,
  output logic       card_new,
  output logic [7:0] last_r1
);
  localparam int WAKE_BYTES = (WAKE_CYCLES + 7) / 8;

  logic       go, byte_done, ev_timeout, ev_retry_over;
  logic [7:0] tx_byte, rx_byte;

  sdspi_shift #(.DIV(CLK_DIV)) u_shift (
    .clk (clk),
    .rst_n(rst_n),
    .go  (go),
    .tx  (tx_byte),
    .miso(miso),
    .done(byte_done),
    .rx  (rx_byte),
    .sck (sck),
    .mosi(mosi)
  );

  sdspi_seq #(
    .WAKE_BYTES (WAKE_BYTES),
    .POLL_LIMIT (POLL_LIMIT),
    .RETRY_LIMIT(RETRY_LIMIT)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (byte_done),
    .rx           (rx_byte),
    .go           (go),
    .tx           (tx_byte),
    .cs_n         (cs_n),
    .busy         (busy),
    .ready        (ready),
    .error        (error),
    .card_new     (card_new),
    .last_r1      (last_r1),
    .ev_timeout   (ev_timeout),
    .ev_retry_over(ev_retry_over)
  );
endmodule

// File: rtl/sdspi_boot_chk.sv
module sdspi_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       mosi,
  input logic       busy,
  input logic       ready,
  input logic       error,
  input logic [7:0] last_r1,
  input logic       ev_timeout,
  input logic       ev_retry_over
);
  logic       sck_q;
  logic [7:0] hi_rises;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      sck_q    <= 1'b0;
      hi_rises <= 8'd0;
    end else begin
      sck_q <= sck;
      if (sck && !sck_q && cs_n && hi_rises != 8'hFF) hi_rises <= hi_rises + 8'd1;
    end
  end

  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_wake_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_rises >= 8'd74);
  p_timeout_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> last_r1 == 8'hFF);
  p_retry_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry_over |=> last_r1 == 8'h01);
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!busy && last_r1 == 8'h00));
  p_idle_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && mosi));
  p_flags_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ready && !error));
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && error));
endmodule

bind sdspi_boot sdspi_boot_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sck          (sck),
  .mosi         (mosi),
  .busy         (busy),
  .ready        (ready),
  .error        (error),
  .last_r1      (last_r1),
  .ev_timeout   (ev_timeout),
  .ev_retry_over(ev_retry_over)
);

// File: tb/sdspi_boot_bench.sv
module sdspi_boot_bench;
  localparam int DIV = 2;
  localparam int RL  = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b1;
  logic cs_n, sck, mosi, busy, ready, error, card_new;
  logic [7:0] last_r1;

  always #2 clk = ~clk;

  sdspi_boot #(.CLK_DIV(DIV), .WAKE_CYCLES(80), .POLL_LIMIT(8), .RETRY_LIMIT(RL)) u_sdspi_boot (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy), .ready(ready),
    .error(error), .card_new(card_new), .last_r1(last_r1)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // card personality
  int lat = 1, c0 = 1, m8 = 0, n41 = 0, c16 = 0;
  bit mute = 0;
  int expq[$];

  // ---------------- card model ----------------
  logic [7:0] in_sh = 8'h00;
  logic [7:0] out_b = 8'hFF;
  int bitn = 0, a41 = 0, hi_rise = 0;
  int fr[$];
  int rsp[$];

  task automatic build_rsp(int idx);
    rsp.delete();
    repeat (lat) rsp.push_back(8'hFF);
    case (idx)
      0: begin a41 = 0; if (mute) rsp.delete(); else rsp.push_back(c0); end
      8: case (m8)
           0: begin rsp.push_back(8'h01); rsp.push_back(0); rsp.push_back(0); rsp.push_back(1); rsp.push_back(8'hAA); end
           1: rsp.push_back(8'h05);
           2: begin rsp.push_back(8'h01); rsp.push_back(0); rsp.push_back(0); rsp.push_back(1); rsp.push_back(8'h55); end
           default: rsp.push_back(8'h09);
         endcase
      55: rsp.push_back(8'h01);
      41: begin rsp.push_back(a41 < n41 ? 8'h01 : 8'h00); a41++; end
      16: rsp.push_back(c16);
      default: rsp.push_back(8'h04);
    endcase
  endtask

  task automatic card_byte(logic [7:0] b);
    int cur, e;
    cur = {23'd0, cs_n, b};
    if (expq.size() == 0) chk(0, "R3", "unexpected bus byte {cs,mosi}", cur, 0);
    else begin
      e = expq.pop_front();
      chk(cur == e, cs_n ? "R9" : "R3", "bus byte {cs,mosi}", cur, e);
    end
    if (cs_n) begin
      fr.delete(); rsp.delete(); out_b = 8'hFF;
    end else begin
      if (fr.size() > 0 || (rsp.size() == 0 && b[7:6] == 2'b01)) begin
        fr.push_back(b);
        if (fr.size() == 6) begin build_rsp(fr[0] & 63); fr.delete(); end
      end
      out_b = (rsp.size() > 0) ? 8'(rsp.pop_front()) : 8'hFF;
    end
    miso = cs_n ? 1'b1 : out_b[7];
  endtask

  always @(posedge sck) begin
    if (cs_n) hi_rise++;
    in_sh = {in_sh[6:0], mosi};
    bitn++;
    if (bitn == 8) begin bitn = 0; card_byte(in_sh); end
  end

  always @(negedge sck) if (bitn != 0) miso = cs_n ? 1'b1 : out_b[3'(7 - bitn)];

  always @(negedge cs_n) if (rst_n) chk(hi_rise >= 74, "R2", "SCK rises with cs high before select", hi_rise, 74);

  // -------- per-clock comparison --------
  logic psck = 1'b0, pmosi = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (!busy) chk(sck == 0 && cs_n == 1 && mosi == 1, "R11", "idle pins {sck,cs,mosi}",
                   {29'd0, sck, cs_n, mosi}, 3);
    chk(!(ready && error), "R11", "ready and error together", {ready, error}, 0);
    if (busy) chk(!ready && !error, "R11", "flags while busy", {ready, error}, 0);
    if (sck && psck) chk(mosi == pmosi, "R1", "MOSI moved while SCK high", mosi, pmosi);
    psck = sck; pmosi = mosi;
  end

  // -------- expected stream builder --------
  function automatic void px(bit c, int b); expq.push_back({23'd0, c, 8'(b)}); endfunction
  function automatic void pframe(int idx, int arg, int crc);
    px(0, 64 | idx); px(0, (arg >> 24) & 255); px(0, (arg >> 16) & 255);
    px(0, (arg >> 8) & 255); px(0, arg & 255); px(0, crc);
  endfunction
  function automatic void ppoll(int n); repeat (n) px(0, 255); endfunction
  function automatic void ptail(); px(1, 255); endfunction

  task automatic model(output bit e_rdy, output bit e_err, output bit e_new, output int e_r1);
    e_rdy = 0; e_err = 0; e_new = 0; e_r1 = 255;
    repeat (10) px(1, 255);
    pframe(0, 0, 'h95);
    if (mute) begin ppoll(8); ptail(); e_err = 1; return; end
    ppoll(lat + 1); ptail(); e_r1 = c0;
    if (c0 != 1) begin e_err = 1; return; end
    pframe(8, 'h1AA, 'h87);
    if (m8 == 0 || m8 == 2) begin
      ppoll(lat + 5); ptail(); e_r1 = 1; e_new = 1;
      if (m8 == 2) begin e_err = 1; return; end
    end else if (m8 == 1) begin
      ppoll(lat + 1); ptail(); e_r1 = 5;
    end else begin
      ppoll(lat + 1); ptail(); e_r1 = 9; e_err = 1; return;
    end
    for (int a = 0; a < RL; a++) begin
      pframe(55, 0, 0); ppoll(lat + 1); ptail();
      pframe(41, e_new ? 'h4000_0000 : 0, 0); ppoll(lat + 1); ptail();
      if (a >= n41) begin e_r1 = 0; break; end
      e_r1 = 1;
      if (a == RL - 1) begin e_err = 1; return; end
    end
    pframe(16, 512, 0); ppoll(lat + 1); ptail();
    e_r1 = c16;
    if (c16 == 0) e_rdy = 1; else e_err = 1;
  endtask

  task automatic scen(string tag, int l, int c0_i, bit mu, int m8_i, int n41_i, int c16_i, bit poke);
    bit er, ee, en;
    int e1;
    lat = l; c0 = c0_i; mute = mu; m8 = m8_i; n41 = n41_i; c16 = c16_i;
    expq.delete(); hi_rise = 0;
    model(er, ee, en, e1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1, "R11", "busy after start", busy, 1);
    if (poke) begin                      // start while busy must be ignored
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R9", "bytes left unsent", expq.size(), 0);
    chk(ready == er, tag, "ready", ready, er);
    chk(error == ee, tag, "error", error, ee);
    chk(card_new == en, "R6", "card_new", card_new, en);
    chk(last_r1 == 8'(e1), "R10", "last_r1", last_r1, e1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sck == 0 && mosi == 1, "R12", "reset pins {cs,sck,mosi}", {cs_n, sck, mosi}, 5);
        chk(busy == 0 && ready == 0 && error == 0 && card_new == 0, "R12", "reset flags",
            {busy, ready, error, card_new}, 0);
        chk(last_r1 == 8'hFF, "R12", "reset last_r1", last_r1, 8'hFF);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        scen("R7", 1, 1, 0, 0, 2, 0, 1);   // high capacity, two retries, stray start
        scen("R6", 0, 1, 0, 1, 0, 0, 0);   // standard capacity, ready at once
        scen("R5", 1, 0, 0, 0, 0, 0, 0);   // reset answered 0x00
        scen("R4", 1, 1, 1, 0, 0, 0, 0);   // silent card: timeout
        scen("R7", 2, 1, 0, 1, 10, 0, 0);  // never leaves idle: retry limit
        scen("R6", 1, 1, 0, 2, 0, 0, 0);   // bad echo byte
        scen("R6", 0, 1, 0, 3, 0, 0, 0);   // unknown interface answer
        scen("R8", 3, 1, 0, 0, 0, 4, 0);   // block length rejected
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule